// File: doc/BRIEF.md
# Staggered Channel Reset Sequencer

This block drives a reset vector for four lanes through a staggered ramp. One start request sets the resets of the lanes one at a time, beginning with the highest lane. Once every bit is set, it clears them one at a time in the reverse order. Lane 0 is the master lane. It is the last lane to enter reset and the first to leave it. Each step of the ramp holds for a fixed interval. The interval is a count of system clocks, derived from the clock-frequency parameter as one thousandth of a second. A simulation can therefore pick a low frequency and get short steps.

The sequencer drives only the per-lane reset vector. It does not touch the analog lane settings or the Ethernet control and status registers. A busy output covers the whole ramp, and a one-cycle done pulse marks the end of the ramp. A synchronous abort input returns the block to idle at any point.

Top module: `rst_stagger_seq`

## Requirements
- R1: While `rst_ni` is low, and in idle after it, `lane_rst_o` is 0x0, `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` sampled high in idle (with `abort_i` low) makes `lane_rst_o` 0x8 and `busy_o` 1 from the next clock edge.
- R3: `lane_rst_o` bit i is the reset of lane i (bit 3 is lane 3, bit 0 is the master lane). After a start, the vector takes the values 0x8, 0xC, 0xE, 0xF, 0xE, 0xC, 0x8, 0x0 in that order.
- R4: Each of the eight values holds for exactly `CLK_FREQ_HZ/1000` clock cycles. `busy_o` stays high for 8 such intervals, counted from the start edge.
- R5: Consecutive values of the vector differ in at most one bit. Bit 0 is set only while all four bits are set.
- R6: `done_o` is high for exactly one cycle. That cycle begins at the edge where the final 0x0 value has held its full interval, and `busy_o` falls at the same edge.
- R7: A `start_i` that arrives while `busy_o` is high is ignored: the vector, its timing and the done pulse are unchanged.
- R8: `abort_i` sampled high forces `lane_rst_o` to 0x0, `busy_o` to 0 and `done_o` to 0 from the next edge, with no done pulse. It wins over a `start_i` in the same cycle.
- R9: A start sampled in the cycle where `done_o` is high begins a new ramp at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| abort_i | input | 1 | Synchronous abort, returns the block to idle |
| lane_rst_o | output | N_LANES | Per-lane reset vector, bit 0 = master lane |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle pulse at the end of the ramp |

## Verification
The hardest cases are a start or an abort that lands on the very edge where the step counter advances or where the done pulse fires. Random stimulus almost never hits that edge. The bench runs one full ramp for each clock offset from the start edge to one past the final interval. In each run it injects either a second start or an abort at that offset. Every cycle is compared with an arithmetic model of the ramp, so every step boundary and the done edge meet both kinds of interference.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int unsigned TICKS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expire_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST)  cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned N_STEPS = 8,
  localparam int unsigned SW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          expire_i,
  output logic          busy_o,
  output logic          busy_nxt_o,
  output logic [SW-1:0] step_nxt_o,
  output logic          done_nxt_o
);
  localparam logic [SW-1:0] LAST_STEP = SW'(N_STEPS - 1);

  seq_state_e state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
      step_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_RUN;
          step_d  = '0;
        end
        ST_RUN: if (expire_i) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_IDLE;
            step_d  = '0;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign busy_nxt_o = (state_d == ST_RUN);
  assign step_nxt_o = step_d;
  assign done_nxt_o = done_d;
endmodule

// File: rtl/rst_seq_pattern.sv
module rst_seq_pattern #(
  parameter int unsigned N_LANES = 4,
  localparam int unsigned SW = $clog2(2 * N_LANES)
) (
  input  logic [SW-1:0]      step_i,
  output logic [N_LANES-1:0] vec_o
);
  // ramp on: top step+1 bits; ramp off: top N-1-(step-N) bits
  for (genvar i = 0; i < N_LANES; i++) begin : g_bit
    always_comb begin
      if (int'(step_i) < int'(N_LANES))
        vec_o[i] = (i >= int'(N_LANES) - 1 - int'(step_i));
      else
        vec_o[i] = (i >= int'(step_i) - int'(N_LANES) + 1);
    end
  end
endmodule

// File: rtl/rst_stagger_seq.sv
module rst_stagger_seq #(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned N_LANES     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  output logic [N_LANES-1:0] lane_rst_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned TICKS   = (CLK_FREQ_HZ / 1000 > 0) ? CLK_FREQ_HZ / 1000 : 1;
  localparam int unsigned N_STEPS = 2 * N_LANES;
  localparam int unsigned SW      = $clog2(N_STEPS);

  logic          expire;
  logic          busy_nxt, done_nxt;
  logic [SW-1:0] step_nxt;
  logic [N_LANES-1:0] vec_nxt, lane_rst_q;
  logic          done_q;

  rst_seq_timer #(.TICKS(TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (abort_i),
    .en_i     (busy_o),
    .expire_o (expire)
  );

  rst_seq_ctrl #(.N_STEPS(N_STEPS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .expire_i   (expire),
    .busy_o     (busy_o),
    .busy_nxt_o (busy_nxt),
    .step_nxt_o (step_nxt),
    .done_nxt_o (done_nxt)
  );

  rst_seq_pattern #(.N_LANES(N_LANES)) u_pat (
    .step_i (step_nxt),
    .vec_o  (vec_nxt)
  );

  // registered so lane resets never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_rst_q <= '0;
      done_q     <= 1'b0;
    end else begin
      lane_rst_q <= busy_nxt ? vec_nxt : '0;
      done_q     <= done_nxt;
    end
  end

  assign lane_rst_o = lane_rst_q;
  assign done_o     = done_q;
endmodule

// File: rtl/rst_stagger_seq_chk.sv
module rst_stagger_seq_chk #(
  parameter int unsigned N_LANES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               abort_i,
  input logic [N_LANES-1:0] lane_rst_o,
  input logic               busy_o,
  input logic               done_o
);
  localparam logic [N_LANES-1:0] FIRST = {1'b1, {(N_LANES-1){1'b0}}};

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> lane_rst_o == '0);

  // R2
  start_first_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !abort_i) |=> (busy_o && lane_rst_o == FIRST));

  // R5
  one_bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $countones(lane_rst_o ^ $past(lane_rst_o)) <= 1);

  // R5
  master_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_rst_o[0] |-> &lane_rst_o);

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && lane_rst_o == '0));

  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (lane_rst_o == '0 && !busy_o && !done_o));
endmodule

bind rst_stagger_seq rst_stagger_seq_chk #(.N_LANES(N_LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .lane_rst_o (lane_rst_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_rst_stagger_seq.sv
module sim_rst_stagger_seq;
  localparam int unsigned FREQ = 5000;
  localparam int T    = FREQ / 1000;
  localparam int SPAN = 8 * T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [3:0] lane_rst;
  logic busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  rst_stagger_seq #(.CLK_FREQ_HZ(FREQ), .N_LANES(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .lane_rst_o(lane_rst), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_vec(input int s);
    if (s < 4) return (15 << (3 - s)) & 15;
    return (15 << (s - 3)) & 15;
  endfunction

  // kind 0: clean; 1: extra start at edge k; 2: abort at edge k; 3: abort+start at edge k
  task automatic run(input int kind, input int k);
    bit killed = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c <= SPAN + 1; c++) begin
      int ev, eb, ed;
      if (kind >= 2 && c >= k) killed = 1;
      ev = (killed || c >= SPAN) ? 0 : exp_vec(c / T);
      eb = (!killed && c < SPAN) ? 1 : 0;
      ed = (!killed && c == SPAN) ? 1 : 0;
      if (kind == 0 && c == 0) chk("R2", lane_rst, 8);
      chk(killed ? "R8" : (kind == 1 ? "R7" : "R3"), lane_rst, ev);
      chk(killed ? "R8" : "R4", busy, eb);
      chk(killed ? "R8" : "R6", done, ed);
      if (lane_rst[0]) chk("R5", lane_rst, 15);
      start = 1'b0; abort = 1'b0;
      if (c + 1 == k) begin
        if (kind == 1 || kind == 3) start = 1'b1;
        if (kind >= 2) abort = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0; abort = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #25;
    // R1: in reset
    chk("R1", lane_rst, 0); chk("R1", busy, 0); chk("R1", done, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", lane_rst, 0); chk("R1", busy, 0); chk("R1", done, 0);

    run(0, 0);
    for (int k = 1; k <= SPAN; k++) run(1, k);  // R7 sweep
    for (int k = 1; k <= SPAN; k++) run(2, k);  // R8 sweep
    for (int k = 1; k <= SPAN; k += 3) run(3, k);  // R8 abort beats start

    // R8: abort while idle together with start keeps block idle
    @(negedge clk); start = 1'b1; abort = 1'b1;
    @(negedge clk); start = 1'b0; abort = 1'b0;
    chk("R8", busy, 0); chk("R8", lane_rst, 0);

    // R9: start sampled in the done cycle
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SPAN) @(negedge clk);
    chk("R6", done, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9", lane_rst, 8); chk("R9", busy, 1); chk("R9", done, 0);
    repeat (SPAN) @(negedge clk);
    chk("R9", done, 1);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule